// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block models the command interface of a small NOR-style flash array. A host drives a synchronous bus with an address, write data, a one-cycle write strobe and a one-cycle read strobe. Every write is matched against multi-cycle unlock sequences. A matching sequence starts one of three things: a standard program, entry into a fast program mode, or a chip erase. Programs and erases run as timed embedded operations on an internal register array. While one is running, the `ready` output stays low and reads return a status byte instead of array data.

The state machine has thirteen states:

- Read side: `ST_READ` (array read), `ST_UNLK1` and `ST_UNLK2` (first and second unlock seen), and `ST_PGM_ARG` (waiting for the program address and data).
- Erase entry: `ST_ERS_SET` (set-up seen), `ST_ERS_UNLK1` and `ST_ERS_UNLK2` (second unlock pair).
- Fast program mode: `ST_BYP_IDLE`, `ST_BYP_ARG` (waiting for address and data) and `ST_BYP_EXIT` (first exit write seen).
- Embedded operations: `ST_PGM_RUN` (program), `ST_ERS_ZERO` (pre-programs each location to zero, one per cycle) and `ST_ERS_ONES` (erase delay, then every location is set to ones).

The transitions are named here:

- `unlock1`: ST_READ to ST_UNLK1.
- `unlock2`: ST_UNLK1 to ST_UNLK2.
- `cmd_prog`, `cmd_fast` and `cmd_setup`: from ST_UNLK2.
- `prog_arg`: to ST_PGM_RUN.
- `ers_unlock1`, `ers_unlock2` and `cmd_chip`: the erase path.
- `fast_prog`: ST_BYP_IDLE to ST_BYP_ARG.
- `fast_exit1`: ST_BYP_IDLE to ST_BYP_EXIT.
- `fast_exit2`: ST_BYP_EXIT to ST_READ.
- `fast_abort`: ST_BYP_EXIT back to ST_BYP_IDLE.
- `prog_done`: back to ST_READ or ST_BYP_IDLE.
- `zero_done`: ST_ERS_ZERO to ST_ERS_ONES.
- `erase_done`: ST_ERS_ONES to ST_READ.
- `seq_break`: any broken sequence back to ST_READ.

Top module: `flash_cmd_top`

## Requirements
- R1: After hardware reset `ready` is 1 and `rd_valid` is 0; each read strobe gives `rd_valid` = 1 exactly one cycle later, with the data of the addressed word when idle.
- R2: The writes AAh@555h, 55h@2AAh, A0h@555h followed by data D at address X start a program: `ready` is 0 for PGM_CYCLES cycles, then the word at X reads back old AND D.
- R3: Programming never turns a 0 bit into 1; a program whose data has a 1 where the stored word has a 0 reports bit 5 = 1 in busy status reads, else bit 5 = 0.
- R4: The writes AAh@555h, 55h@2AAh, 20h@555h enter fast program mode, where a write of A0h followed by data D at address X programs X with no unlock cycles (PGM_CYCLES busy cycles).
- R5: In fast program mode every write other than A0h and 90h is ignored, unlock and erase sequences included; after 90h then 00h the block is back in array read mode, where a lone A0h and a following data write program nothing.
- R6: The six writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h start a chip erase: `ready` is 0 for DEPTH+ERASE_CYCLES cycles, after which every word reads FFh.
- R7: Writes that arrive while `ready` is 0 are ignored: they change no memory word and start no sequence.
- R8: A read while `ready` is 0 returns status: bit 7 is the complement of bit 7 of the data being programmed (0 during erase), and bit 6 inverts on each such read, starting at 0 after reset.
- R9: A write that does not match the next expected step of a sequence returns the decoder to array read mode and changes no memory.
- R10: Driving `rst_n` low during an operation stops it at once: `ready` is 1 while reset is held, and the target word keeps its old value.
- R11: In fast program mode, 90h followed by any value other than 00h leaves the block in fast program mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| bus_addr | input | ADDR_W | Address for writes and reads |
| bus_wdata | input | DATA_W | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_data | output | DATA_W | Array word or status byte |
| rd_valid | output | 1 | rd_data is valid (one cycle after rd_en) |
| ready | output | 1 | 1 when idle, 0 during program or erase |

## Verification
The program path is tried with data that only clears bits and with data that tries to set cleared bits. This separates AND semantics and the bit 5 fail flag from plain overwriting. Sequences broken at the second and third cycles, and writes during busy periods, are each followed by a write that would complete a program if the broken or ignored write had advanced the decoder. This exposes any decoder that does not return to array read mode. Fast program mode is given unlock, erase, bad-exit and correct-exit patterns, which tell which commands it accepts. Status reads are made during both a program and an erase, so the toggle bit and the two meanings of bit 7 can be told apart.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef enum logic [3:0] {
        ST_READ,
        ST_UNLK1,
        ST_UNLK2,
        ST_PGM_ARG,
        ST_ERS_SET,
        ST_ERS_UNLK1,
        ST_ERS_UNLK2,
        ST_BYP_IDLE,
        ST_BYP_ARG,
        ST_BYP_EXIT,
        ST_PGM_RUN,
        ST_ERS_ZERO,
        ST_ERS_ONES
    } fsm_state_e;

    localparam logic [7:0] CMD_KEY_A    = 8'hAA;
    localparam logic [7:0] CMD_KEY_B    = 8'h55;
    localparam logic [7:0] CMD_PROGRAM  = 8'hA0;
    localparam logic [7:0] CMD_FAST     = 8'h20;
    localparam logic [7:0] CMD_SETUP    = 8'h80;
    localparam logic [7:0] CMD_CHIP     = 8'h10;
    localparam logic [7:0] CMD_EXIT1    = 8'h90;
    localparam logic [7:0] CMD_EXIT2    = 8'h00;

    localparam int unsigned KEY_ADDR_A  = 'h555;
    localparam int unsigned KEY_ADDR_B  = 'h2AA;

    localparam int unsigned POLL_BIT    = 7;
    localparam int unsigned TOGGLE_BIT  = 6;
    localparam int unsigned FAIL_BIT    = 5;

endpackage

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W       = 11,
    parameter int DATA_W       = 8,
    parameter int DEPTH        = 16,
    parameter int PGM_CYCLES   = 8,
    parameter int ERASE_CYCLES = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [DATA_W-1:0]         wr_data,
    output logic                      busy,
    output logic                      erasing,
    output logic                      byp_mode,
    output logic [$clog2(DEPTH)-1:0]  tgt_idx,
    output logic [DATA_W-1:0]         tgt_data,
    output logic                      do_pgm,
    output logic                      do_zero,
    output logic [$clog2(DEPTH)-1:0]  zero_idx,
    output logic                      do_ones
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int MAXC  = (PGM_CYCLES > ERASE_CYCLES) ?
                           ((PGM_CYCLES > DEPTH) ? PGM_CYCLES : DEPTH) :
                           ((ERASE_CYCLES > DEPTH) ? ERASE_CYCLES : DEPTH);
    localparam int CNT_W = $clog2(MAXC + 1);

    fsm_state_e        state, nxt;
    logic [CNT_W-1:0]  cnt, cnt_nxt;
    logic              byp_nxt, latch_en;
    logic              at_a, at_b, key_a, key_b;

    assign at_a  = (wr_addr == ADDR_W'(KEY_ADDR_A));
    assign at_b  = (wr_addr == ADDR_W'(KEY_ADDR_B));
    assign key_a = at_a && (wr_data[7:0] == CMD_KEY_A);
    assign key_b = at_b && (wr_data[7:0] == CMD_KEY_B);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_READ;
            cnt      <= '0;
            byp_mode <= 1'b0;
            tgt_idx  <= '0;
            tgt_data <= '0;
        end else begin
            state    <= nxt;
            cnt      <= cnt_nxt;
            byp_mode <= byp_nxt;
            if (latch_en) begin
                tgt_idx  <= wr_addr[IDX_W-1:0];
                tgt_data <= wr_data;
            end
        end
    end

    // next state
    always_comb begin
        nxt      = state;
        cnt_nxt  = cnt;
        byp_nxt  = byp_mode;
        latch_en = 1'b0;
        unique case (state)
            ST_READ:      if (wr_en && key_a) nxt = ST_UNLK1;
            ST_UNLK1:     if (wr_en) nxt = key_b ? ST_UNLK2 : ST_READ;
            ST_UNLK2: if (wr_en) begin
                nxt = ST_READ;
                if (at_a) begin
                    case (wr_data[7:0])
                        CMD_PROGRAM: nxt = ST_PGM_ARG;
                        CMD_SETUP:   nxt = ST_ERS_SET;
                        CMD_FAST: begin
                            nxt     = ST_BYP_IDLE;
                            byp_nxt = 1'b1;
                        end
                        default:     nxt = ST_READ;
                    endcase
                end
            end
            ST_PGM_ARG, ST_BYP_ARG: if (wr_en) begin
                latch_en = 1'b1;
                nxt      = ST_PGM_RUN;
                cnt_nxt  = CNT_W'(PGM_CYCLES - 1);
            end
            ST_ERS_SET:   if (wr_en) nxt = key_a ? ST_ERS_UNLK1 : ST_READ;
            ST_ERS_UNLK1: if (wr_en) nxt = key_b ? ST_ERS_UNLK2 : ST_READ;
            ST_ERS_UNLK2: if (wr_en) begin
                if (at_a && wr_data[7:0] == CMD_CHIP) begin
                    nxt     = ST_ERS_ZERO;
                    cnt_nxt = '0;
                end else begin
                    nxt = ST_READ;
                end
            end
            ST_BYP_IDLE: if (wr_en) begin
                if (wr_data[7:0] == CMD_PROGRAM)    nxt = ST_BYP_ARG;
                else if (wr_data[7:0] == CMD_EXIT1) nxt = ST_BYP_EXIT;
            end
            ST_BYP_EXIT: if (wr_en) begin
                if (wr_data[7:0] == CMD_EXIT2) begin
                    nxt     = ST_READ;
                    byp_nxt = 1'b0;
                end else begin
                    nxt = ST_BYP_IDLE;
                end
            end
            ST_PGM_RUN: begin
                if (cnt == '0) nxt = byp_mode ? ST_BYP_IDLE : ST_READ;
                else           cnt_nxt = cnt - 1'b1;
            end
            ST_ERS_ZERO: begin
                if (cnt == CNT_W'(DEPTH - 1)) begin
                    nxt     = ST_ERS_ONES;
                    cnt_nxt = CNT_W'(ERASE_CYCLES - 1);
                end else begin
                    cnt_nxt = cnt + 1'b1;
                end
            end
            ST_ERS_ONES: begin
                if (cnt == '0) nxt = ST_READ;
                else           cnt_nxt = cnt - 1'b1;
            end
            default: nxt = ST_READ;
        endcase
    end

    // outputs
    always_comb begin
        busy     = (state == ST_PGM_RUN) || (state == ST_ERS_ZERO) || (state == ST_ERS_ONES);
        erasing  = (state == ST_ERS_ZERO) || (state == ST_ERS_ONES);
        do_pgm   = (state == ST_PGM_RUN) && (cnt == '0);
        do_zero  = (state == ST_ERS_ZERO);
        zero_idx = cnt[IDX_W-1:0];
        do_ones  = (state == ST_ERS_ONES) && (cnt == '0);
    end

endmodule

// File: rtl/flash_cell_array.sv
module flash_cell_array #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16
) (
    input  logic                      clk,
    input  logic                      do_pgm,
    input  logic [$clog2(DEPTH)-1:0]  pgm_idx,
    input  logic [DATA_W-1:0]         pgm_data,
    input  logic                      do_zero,
    input  logic [$clog2(DEPTH)-1:0]  zero_idx,
    input  logic                      do_ones,
    input  logic [$clog2(DEPTH)-1:0]  rd_idx,
    output logic [DATA_W-1:0]         rd_word,
    output logic [DATA_W-1:0]         tgt_word
);
    localparam int IDX_W = $clog2(DEPTH);

    logic [DATA_W-1:0] cells [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (do_ones)
                cells[i] <= '1;
            else if (do_zero && zero_idx == IDX_W'(i))
                cells[i] <= '0;
            else if (do_pgm && pgm_idx == IDX_W'(i))
                cells[i] <= cells[i] & pgm_data;
        end
    end

    assign rd_word  = cells[rd_idx];
    assign tgt_word = cells[pgm_idx];

endmodule

// File: rtl/flash_read_port.sv
module flash_read_port
    import flash_cmd_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              busy,
    input  logic              erasing,
    input  logic [DATA_W-1:0] tgt_data,
    input  logic [DATA_W-1:0] tgt_word,
    input  logic [DATA_W-1:0] arr_word,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    logic              tog;
    logic              fail;
    logic [DATA_W-1:0] status;

    assign fail = !erasing && (|(tgt_data & ~tgt_word));

    always_comb begin
        status             = '0;
        status[POLL_BIT]   = erasing ? 1'b0 : ~tgt_data[POLL_BIT];
        status[TOGGLE_BIT] = tog;
        status[FAIL_BIT]   = fail;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
            tog      <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                rd_data <= busy ? status : arr_word;
                if (busy) tog <= ~tog;
            end
        end
    end

endmodule

// File: rtl/flash_cmd_top.sv
module flash_cmd_top #(
    parameter int ADDR_W       = 11,
    parameter int DATA_W       = 8,
    parameter int DEPTH        = 16,
    parameter int PGM_CYCLES   = 8,
    parameter int ERASE_CYCLES = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              ready
);
    localparam int IDX_W = $clog2(DEPTH);

    logic              busy, erasing, byp_mode;
    logic              do_pgm, do_zero, do_ones;
    logic [IDX_W-1:0]  tgt_idx, zero_idx;
    logic [DATA_W-1:0] tgt_data, tgt_word, arr_word;

    flash_seq_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH),
        .PGM_CYCLES(PGM_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(bus_addr),
        .wr_data(bus_wdata), .busy(busy), .erasing(erasing),
        .byp_mode(byp_mode), .tgt_idx(tgt_idx), .tgt_data(tgt_data),
        .do_pgm(do_pgm), .do_zero(do_zero), .zero_idx(zero_idx),
        .do_ones(do_ones)
    );

    flash_cell_array #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_array (
        .clk(clk), .do_pgm(do_pgm), .pgm_idx(tgt_idx), .pgm_data(tgt_data),
        .do_zero(do_zero), .zero_idx(zero_idx), .do_ones(do_ones),
        .rd_idx(bus_addr[IDX_W-1:0]), .rd_word(arr_word), .tgt_word(tgt_word)
    );

    flash_read_port #(.DATA_W(DATA_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .busy(busy),
        .erasing(erasing), .tgt_data(tgt_data), .tgt_word(tgt_word),
        .arr_word(arr_word), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    assign ready = !busy;

endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk #(
    parameter int DATA_W       = 8,
    parameter int DEPTH        = 16,
    parameter int PGM_CYCLES   = 8,
    parameter int ERASE_CYCLES = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic              rd_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic              ready,
    input logic              erasing,
    input logic              byp_mode,
    input logic              do_pgm,
    input logic [DATA_W-1:0] tgt_word
);
    localparam int LIMIT = (DEPTH + ERASE_CYCLES > PGM_CYCLES) ?
                           DEPTH + ERASE_CYCLES : PGM_CYCLES;
    localparam int RUN_W = $clog2(LIMIT + 2);

    logic [RUN_W-1:0] busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      busy_run <= '0;
        else if (ready)                  busy_run <= '0;
        else if (busy_run != '1)         busy_run <= busy_run + 1'b1;
    end

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid); // R1
    AST_NO_SPURIOUS_RD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid); // R1
    AST_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        do_pgm |=> ((tgt_word & ~$past(tgt_word)) == '0)); // R3
    AST_FAST_NO_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
        byp_mode |-> !erasing); // R5
    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= RUN_W'(LIMIT)); // R6
    AST_ERASE_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && erasing) |=> !rd_data[7]); // R8
    AST_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !ready && $past(rd_en && !ready)) |=> (rd_data[6] != $past(rd_data[6]))); // R8
    AST_RESET_READY: assert property (@(posedge clk)
        !rst_n |-> ready); // R10

endmodule

bind flash_cmd_top flash_cmd_chk #(
    .DATA_W(DATA_W), .DEPTH(DEPTH),
    .PGM_CYCLES(PGM_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_valid(rd_valid),
    .rd_data(rd_data), .ready(ready), .erasing(erasing),
    .byp_mode(byp_mode), .do_pgm(do_pgm), .tgt_word(tgt_word)
);

// File: tb/flash_cmd_top_tb.sv
module flash_cmd_top_tb;
    localparam int ADDR_W = 11;
    localparam int DATA_W = 8;
    localparam int DEPTH  = 16;
    localparam int PGM    = 8;
    localparam int ERS    = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [DATA_W-1:0] rd_data;
    logic              rd_valid;
    logic              ready;

    int errors = 0;
    int checks = 0;
    bit exp_tog = 1'b0;

    typedef struct {
        logic [7:0] exp;
        logic [7:0] mask;
        string      tag;
    } sb_item_t;
    sb_item_t sb[$];

    always #10 clk = ~clk;

    flash_cmd_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH),
                    .PGM_CYCLES(PGM), .ERASE_CYCLES(ERS)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data),
        .rd_valid(rd_valid), .ready(ready)
    );

    task automatic chk(int act, int exp, string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        bus_addr = ADDR_W'(a); bus_wdata = DATA_W'(d); wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(int a, logic [7:0] exp, logic [7:0] mask, string tag);
        sb_item_t it;
        @(negedge clk);
        bus_addr = ADDR_W'(a); rd_en = 1'b1;
        it.exp = exp; it.mask = mask; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rd_status(bit b7, bit b5, string tag);
        rd(0, {b7, exp_tog, b5, 5'b0}, 8'hE0, tag);
        exp_tog = ~exp_tog;
    endtask

    task automatic std_prog(int a, int d);
        wr('h555, 'hAA); wr('h2AA, 'h55); wr('h555, 'hA0); wr(a, d);
    endtask

    task automatic chip_erase();
        wr('h555, 'hAA); wr('h2AA, 'h55); wr('h555, 'h80);
        wr('h555, 'hAA); wr('h2AA, 'h55); wr('h555, 'h10);
    endtask

    task automatic wait_busy(int exp, string tag);
        int n = 0;
        while (!ready) begin n++; @(negedge clk); end
        chk(n, exp, tag);
    endtask

    task automatic wait_idle();
        while (!ready) @(negedge clk);
    endtask

    // monitor: compares each returned read against the scoreboard
    always @(negedge clk) begin
        if (rd_valid) begin
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL unexpected read actual=%0h expected=none", rd_data);
            end else begin
                sb_item_t it;
                it = sb.pop_front();
                if ((rd_data & it.mask) !== (it.exp & it.mask)) begin
                    errors++;
                    $display("FAIL %s actual=%0h expected=%0h", it.tag,
                             rd_data & it.mask, it.exp & it.mask);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(ready, 1, "R1 ready in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready, 1, "R1 ready after reset");
        chk(rd_valid, 0, "R1 rd_valid after reset");

        // chip erase from unknown content
        chip_erase();
        wait_busy(DEPTH + ERS, "R6 erase busy length");
        rd(0, 8'hFF, 8'hFF, "R6 word0 erased");
        rd(5, 8'hFF, 8'hFF, "R6 word5 erased");
        rd(15, 8'hFF, 8'hFF, "R6 word15 erased; R1 idle read");

        // standard program
        std_prog(3, 'h5A);
        wait_busy(PGM, "R2 program busy length");
        rd(3, 8'h5A, 8'hFF, "R2 programmed word");

        // attempt to set cleared bits, status polled during busy
        std_prog(3, 'hF0);
        rd_status(1'b0, 1'b1, "R3 fail flag / R8 poll bit");
        rd_status(1'b0, 1'b1, "R8 toggle second read");
        wait_idle();
        rd(3, 8'h50, 8'hFF, "R3 only clears bits");

        // clean program status
        std_prog(4, 'h3C);
        rd_status(1'b1, 1'b0, "R8 poll bit complement, R3 no fail");
        rd_status(1'b1, 1'b0, "R8 toggle");
        wait_idle();
        rd(4, 8'h3C, 8'hFF, "R2 word4");

        // erase status
        chip_erase();
        rd_status(1'b0, 1'b0, "R8 erase poll bit zero");
        rd_status(1'b0, 1'b0, "R8 erase toggle");
        wait_idle();
        rd(3, 8'hFF, 8'hFF, "R6 word3 erased");

        // broken sequences
        wr('h555, 'hAA); wr('h2AA, 'h55); wr('h555, 'h77); wr(7, 'h00);
        chk(ready, 1, "R9 bad third cycle no busy");
        wr('h555, 'hAA); wr('h123, 'h55); wr('h555, 'hA0); wr(8, 'h00);
        chk(ready, 1, "R9 bad second address no busy");
        rd(7, 8'hFF, 8'hFF, "R9 word7 unchanged");
        rd(8, 8'hFF, 8'hFF, "R9 word8 unchanged");

        // fast program mode
        wr('h555, 'hAA); wr('h2AA, 'h55); wr('h555, 'h20);
        wr(0, 'hA0); wr(9, 'h12);
        wait_busy(PGM, "R4 fast program busy length");
        rd(9, 8'h12, 8'hFF, "R4 fast programmed word");
        chip_erase();
        chk(ready, 1, "R5 erase ignored in fast mode");
        rd(9, 8'h12, 8'hFF, "R5 word9 kept");
        wr(0, 'hA0); wr(10, 'h0F);
        wait_busy(PGM, "R4 still in fast mode");
        rd(10, 8'h0F, 8'hFF, "R4 word10");
        wr(0, 'h90); wr(0, 'h55);
        wr(0, 'hA0); wr(11, 'hF0);
        wait_busy(PGM, "R11 bad exit stays in fast mode");
        rd(11, 8'hF0, 8'hFF, "R11 word11");
        wr(0, 'h90); wr(0, 'h00);
        wr(0, 'hA0); wr(12, 'h00);
        chk(ready, 1, "R5 exit returns to read mode");
        rd(12, 8'hFF, 8'hFF, "R5 word12 unchanged after exit");

        // writes during busy
        std_prog(13, 'h00);
        wr('h555, 'hAA); wr(14, 'h00);
        wait_idle();
        wr('h2AA, 'h55); wr('h555, 'hA0); wr(15, 'h00);
        chk(ready, 1, "R7 busy writes started nothing");
        rd(13, 8'h00, 8'hFF, "R7 word13 programmed");
        rd(14, 8'hFF, 8'hFF, "R7 word14 untouched");
        rd(15, 8'hFF, 8'hFF, "R7 word15 untouched");

        // hardware reset abort
        std_prog(1, 'h00);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        chk(ready, 1, "R10 ready during reset");
        @(negedge clk);
        rst_n = 1'b1;
        exp_tog = 1'b0;
        @(negedge clk);
        chk(ready, 1, "R10 ready after abort");
        rd(1, 8'hFF, 8'hFF, "R10 word1 unchanged");

        repeat (4) @(negedge clk);
        chk(sb.size(), 0, "R1 all reads returned");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule